// File: doc/BRIEF.md
# Passive-Matrix LCD Row Scan Timing Generator

This block produces the row-scan timing for a passive-matrix LCD driver. Each enabled edge of the display clock is one line period. On each such edge the block moves to the next scan line and drives a one-hot common (row) select vector, with exactly one row active at a time. It also drives a polarity signal that inverts once per frame, which gives a two-frame AC drive waveform.

On the same edge the block latches one line of pixel data from the read port of a dual-port display RAM and holds it on the segment outputs. The RAM read address always points at the line that follows the active one. Its data is therefore already settled when the line boundary arrives.

The segment latch samples the RAM only at line boundaries. Writes from the host side of the RAM between boundaries never reach the displayed line. When the display clock is stopped (`clk_en` low), every output holds its value.

Top module: `lcd_scan_timing`

## Requirements
- R1: A synchronous active-high reset makes row 0 the only active common output. It also drives `fr` low (0 = positive polarity), clears `seg` to zero and sets `rd_addr` to 1.
- R2: After reset, exactly one bit of `com` is high in every cycle.
- R3: On each clock edge with `clk_en` high, the active row moves from index k to index k+1. After the last index (NUM_LINES-1, 64 by default) it returns to index 0.
- R4: `fr` inverts on the enabled edge at which the row index wraps from NUM_LINES-1 to 0, and on no other edge.
- R5: `rd_addr` always equals the index of the row after the active one, wrapping from NUM_LINES-1 to 0.
- R6: On each enabled edge, `seg` takes the value that `rd_data` carried just before that edge. This is the data for the row that becomes active.
- R7: Changes on `rd_data` between enabled edges, such as host writes to the RAM, have no effect on `seg`.
- R8: While `clk_en` is low, `com`, `fr`, `seg` and `rd_addr` all hold their values across clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Display clock running; low halts all scan activity |
| rd_data | input | SEG_W | RAM read data for the line at `rd_addr` |
| com | output | NUM_LINES | One-hot common row select, bit i = row i |
| fr | output | 1 | Frame AC polarity, toggles once per frame |
| rd_addr | output | IDX_W | RAM read address, index of the next row |
| seg | output | SEG_W | Latched segment data of the active row |

## Verification
The bench runs well over three frames with random halts, so the wrap from row 64 to row 0 is crossed several times. A design that toggled polarity one edge early or late, or that wrapped after the wrong count, would show a shifted `fr` or a missing or extra row. Right after each edge the bench overwrites the RAM word that is currently addressed. A segment latch that is transparent, or that latches on every clock instead of every enabled clock, would then show the new word. Halts of several cycles, and a reset in the middle of a frame, expose counters that keep running while stopped and reset values that are wrong.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

    typedef enum logic {
        FR_POS = 1'b0,
        FR_NEG = 1'b1
    } fr_pol_e;

    function automatic fr_pol_e flip_pol(fr_pol_e p);
        return (p == FR_POS) ? FR_NEG : FR_POS;
    endfunction

endpackage

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr
    import lcd_timing_pkg::*;
#(
    parameter int NUM_LINES = 65,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] line_o,
    output logic [IDX_W-1:0] next_o,
    output logic             fr_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] line;
        fr_pol_e          pol;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic             wrap;
    logic [IDX_W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.line == LAST);
        nxt  = wrap ? '0 : st_q.line + 1'b1;
        if (adv) begin
            st_d.line = nxt;
            if (wrap) begin
                st_d.pol = flip_pol(st_q.pol);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{line: '0, pol: FR_POS};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;
    assign next_o = nxt;
    assign fr_o   = st_q.pol;
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv #(
    parameter int NUM_LINES = 65,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic [IDX_W-1:0]     next_idx,
    output logic [NUM_LINES-1:0] com_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] rows;
    } com_t;

    com_t com_d, com_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_row
        always_comb begin
            com_d.rows[i] = adv ? (next_idx == IDX_W'(i)) : com_q.rows[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            com_q.rows <= NUM_LINES'(1);
        end else begin
            com_q <= com_d;
        end
    end

    assign com_o = com_q.rows;
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
    parameter int SEG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [SEG_W-1:0] rd_data,
    output logic [SEG_W-1:0] seg_o
);
    typedef struct packed {
        logic [SEG_W-1:0] data;
    } seg_t;

    seg_t seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (adv) begin
            seg_d.data = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
        end else begin
            seg_q <= seg_d;
        end
    end

    assign seg_o = seg_q.data;
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
    parameter int  NUM_LINES = 65,
    parameter int  SEG_W     = 32,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clk_en,
    input  logic [SEG_W-1:0]     rd_data,
    output logic [NUM_LINES-1:0] com,
    output logic                 fr,
    output logic [IDX_W-1:0]     rd_addr,
    output logic [SEG_W-1:0]     seg
);
    logic [IDX_W-1:0] cur_line;
    logic [IDX_W-1:0] nxt_line;

    lcd_line_ctr #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .adv    (clk_en),
        .line_o (cur_line),
        .next_o (nxt_line),
        .fr_o   (fr)
    );

    lcd_com_drv #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_com (
        .clk      (clk),
        .rst      (rst),
        .adv      (clk_en),
        .next_idx (nxt_line),
        .com_o    (com)
    );

    lcd_seg_latch #(.SEG_W(SEG_W)) u_seg (
        .clk     (clk),
        .rst     (rst),
        .adv     (clk_en),
        .rd_data (rd_data),
        .seg_o   (seg)
    );

    assign rd_addr = nxt_line;

    logic unused_line;
    assign unused_line = ^cur_line;
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
    parameter int  NUM_LINES = 65,
    parameter int  SEG_W     = 32,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clk_en,
    input logic [SEG_W-1:0]     rd_data,
    input logic [NUM_LINES-1:0] com,
    input logic                 fr,
    input logic [IDX_W-1:0]     rd_addr,
    input logic [SEG_W-1:0]     seg
);
    // R2
    one_row_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(com) == 1);

    // R3
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !com[NUM_LINES-1]) |=> (com == ($past(com) << 1)));

    // R3
    wrap_row_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && com[NUM_LINES-1]) |=> com[0]);

    // R4
    fr_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && com[NUM_LINES-1]) |=> (fr != $past(fr)));

    // R4
    fr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(clk_en && com[NUM_LINES-1]) |=> $stable(fr));

    // R5
    addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        com[NUM_LINES-1] |-> (rd_addr == '0));

    // R6
    seg_take_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> (seg == $past(rd_data)));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(com) && $stable(fr) && $stable(seg) && $stable(rd_addr)));
endmodule

bind lcd_scan_timing lcd_scan_chk #(.NUM_LINES(NUM_LINES), .SEG_W(SEG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_en  (clk_en),
    .rd_data (rd_data),
    .com     (com),
    .fr      (fr),
    .rd_addr (rd_addr),
    .seg     (seg)
);

// File: tb/tb_lcd_scan_timing.sv
module tb_lcd_scan_timing;
    localparam int CLK_PERIOD = 10;
    localparam int NL   = 65;
    localparam int SW   = 32;
    localparam int IW   = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b0;
    logic [SW-1:0] rd_data;
    logic [NL-1:0] com;
    logic          fr;
    logic [IW-1:0] rd_addr;
    logic [SW-1:0] seg;

    logic [SW-1:0] mem [NL];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int            exp_line;
    logic          exp_fr;
    logic [SW-1:0] exp_seg;
    logic [SW-1:0] capt;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb rd_data = mem[rd_addr];

    lcd_scan_timing #(.NUM_LINES(NL), .SEG_W(SW)) dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .rd_data(rd_data),
        .com(com), .fr(fr), .rd_addr(rd_addr), .seg(seg)
    );

    function automatic int next_of(int l);
        return (l == NL - 1) ? 0 : l + 1;
    endfunction

    function automatic logic [NL-1:0] onehot_of(int l);
        logic [NL-1:0] v = '0;
        v[l] = 1'b1;
        return v;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2/R3 com", 128'(com), 128'(onehot_of(exp_line)));
        chk("R4 fr", 128'(fr), 128'(exp_fr));
        chk("R5 rd_addr", 128'(rd_addr), 128'(next_of(exp_line)));
        chk("R6 seg", 128'(seg), 128'(exp_seg));
    endtask

    task automatic step(bit en, bit host_wr);
        @(negedge clk);
        clk_en = en;
        if (host_wr) mem[$urandom_range(NL - 1)] = $urandom;
        capt = mem[next_of(exp_line)];
        @(posedge clk);
        #1;
        if (en) begin
            if (exp_line == NL - 1) exp_fr = ~exp_fr;
            exp_line = next_of(exp_line);
            exp_seg  = capt;
        end else begin
            chk("R8 halt hold seg", 128'(seg), 128'(exp_seg));
        end
        check_all();
        // R7: host rewrites the word now on the read port; seg must not move
        mem[next_of(exp_line)] = ~mem[next_of(exp_line)];
        #1;
        chk("R7 seg after host write", 128'(seg), 128'(exp_seg));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clk_en = 1'b1;
        @(posedge clk);
        #1;
        exp_line = 0; exp_fr = 1'b0; exp_seg = '0;
        chk("R1 com", 128'(com), 128'(1));
        chk("R1 fr", 128'(fr), 128'(0));
        chk("R1 seg", 128'(seg), 128'(0));
        chk("R1 rd_addr", 128'(rd_addr), 128'(1));
        @(negedge clk);
        rst = 1'b0;
        clk_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NL; i++) mem[i] = $urandom;
        exp_line = 0; exp_fr = 1'b0; exp_seg = '0;
        do_reset();
        // directed: first advances from row 0
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        // directed: long halt (R8)
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
        // random run over several frames (R3, R4 wraps)
        for (int i = 0; i < 320; i++) step(($urandom_range(9) < 8), ($urandom_range(3) == 0));
        // directed: reset in mid-frame, then a full frame plus one
        do_reset();
        for (int i = 0; i < NL + 2; i++) step(1'b1, 1'b1);
        // directed: halt exactly at last row, then wrap
        while (exp_line != NL - 1) step(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk("R4 fr after wrap from halt", 128'(fr), 128'(exp_fr));
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule